// File: doc/BRIEF.md
# Microcoded Four-Variable Register Network

This block is one processing slot of a page-circulating datapath. A page loads into it in a single cycle. A page holds four signed variables (A to D), four fresh input samples (a to d) and an 8-bit key. Every variable register has its own small ALU. A 12-bit control word, applied on a step cycle, picks one operation and an operand source for each ALU. All selected variables then update together in that one step. An auxiliary bank (A' to D' and K') stays in the slot while pages move through it, so one page can leave values or a key there for a later page to pick up.

Operand wiring is sparse. ALU A can read any variable or any input word. ALUs B, C and D can each read only three things: their own input word, their own auxiliary word, and the variable just before them (B reads A, C reads B, D reads C). Every result is computed from the values held before the step. This lets one word shift a chain of samples down the page. Two of the eight root codes are reserved for word formats this slot does not run. They raise a flag and change nothing.

Top module: `varnet_slot`

## Requirements
- R1: While reset is asserted, all variables, inputs, auxiliary words, both keys and the unsupported flag read zero.
- R2: A cycle with `page_ld` high copies `page_var`, `page_in` and `page_key` into the slot. Any step in that same cycle is ignored.
- R3: The control word is {prefix[11:10], root[9:7], specifier[6:4], suffix[3:0]}. Suffix bit i (bit 0 for A, up to bit 3 for D) enables variable i. Variables whose bit is clear keep their value.
- R4: Operand for ALU A: specifier[2]=0 selects variable specifier[1:0]; specifier[2]=1 selects input word specifier[1:0]. Index 0 means A or a, up to 3 for D or d.
- R5: Operand for ALUs B to D: specifier[1:0]=00 selects the ALU's own input word, 01 its own auxiliary word, 1x the preceding variable. Specifier[2] is not used.
- R6: Every selected variable is computed from the register values held before the step. So one word can load A from an input while B takes old A, C takes old B and D takes old C.
- R7: Root 000 loads the operand. Root 001 adds the operand to the variable. When prefix[0]=0 the add wraps modulo 2^16.
- R8: Root 001 with prefix[0]=1 saturates the signed sum: at 0x7FFF on positive overflow and at 0x8000 on negative overflow.
- R9: Root 010 stores variable minus operand, wrapping. Root 011 stores the low 16 bits of the absolute value of that difference, taken at 17 bits.
- R10: Root 100 stores the operand shifted right arithmetically by prefix+1 places.
- R11: Root 101 exchanges each selected variable with its own auxiliary word. When prefix[1]=1 it also exchanges K and K'.
- R12: Roots 110 and 111 leave every register unchanged. They set `bad_fmt` for exactly the cycle after the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| page_ld | input | 1 | Parallel page load strobe |
| page_var | input | 64 | Incoming variables {D,C,B,A} |
| page_in | input | 64 | Incoming input words {d,c,b,a} |
| page_key | input | 8 | Incoming key |
| step | input | 1 | Apply control word this cycle |
| cw | input | 12 | Control word |
| var_q | output | 64 | Variables {D,C,B,A} |
| aux_q | output | 64 | Auxiliary words {D',C',B',A'} |
| key_q | output | 8 | Key K |
| akey_q | output | 8 | Auxiliary key K' |
| bad_fmt | output | 1 | Unsupported root seen on previous step |

## Verification
The assertions assume that `step` and `page_ld` are held at zero during reset, and that `cw` carries a defined value whenever `step` is high. The bench drives every input on the falling edge and holds `step` for exactly one cycle per word, so each property sees one word per step. The stimulus clears `step` before it checks `bad_fmt`, so the one-cycle pulse can be observed on its own. It also starts every arithmetic corner from a freshly loaded page, so the result of each step is known.

// File: rtl/varnet_slot.sv
module varnet_slot #(
  parameter int DW = 16,
  parameter int KW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            page_ld,
  input  logic [4*DW-1:0] page_var,
  input  logic [4*DW-1:0] page_in,
  input  logic [KW-1:0]   page_key,
  input  logic            step,
  input  logic [11:0]     cw,
  output logic [4*DW-1:0] var_q,
  output logic [4*DW-1:0] aux_q,
  output logic [KW-1:0]   key_q,
  output logic [KW-1:0]   akey_q,
  output logic            bad_fmt
);
  localparam int NV = 4;
  localparam logic [2:0] OP_LD = 3'd0, OP_ADD = 3'd1, OP_SUB = 3'd2,
                         OP_ABD = 3'd3, OP_SHR = 3'd4, OP_SWP = 3'd5;

  logic [DW-1:0] v [NV], inr [NV], aux [NV], opnd [NV], res [NV];
  logic [KW-1:0] key, akey;

  wire [1:0] prefix = cw[11:10];
  wire [2:0] root   = cw[9:7];
  wire [2:0] spec   = cw[6:4];
  wire [3:0] suffix = cw[3:0];
  wire       run    = step && !page_ld;
  wire       known  = root <= OP_SWP;

  function automatic logic [DW-1:0] alu(input logic [2:0] op, input logic [1:0] pf,
                                        input logic [DW-1:0] r, input logic [DW-1:0] x,
                                        input logic [DW-1:0] ax);
    logic [DW:0] s, d, m;
    s = {r[DW-1], r} + {x[DW-1], x};
    d = {r[DW-1], r} - {x[DW-1], x};
    m = d[DW] ? -d : d;
    case (op)
      OP_LD:  alu = x;
      OP_ADD: alu = (pf[0] && s[DW] != s[DW-1]) ?
                    {s[DW], {(DW-1){~s[DW]}}} : s[DW-1:0];
      OP_SUB: alu = d[DW-1:0];
      OP_ABD: alu = m[DW-1:0];
      OP_SHR: alu = $signed(x) >>> ({1'b0, pf} + 3'd1);
      OP_SWP: alu = ax;
      default: alu = r;
    endcase
  endfunction

  assign opnd[0] = spec[2] ? inr[spec[1:0]] : v[spec[1:0]];

  genvar g;
  generate
    for (g = 1; g < NV; g++) begin : g_src
      assign opnd[g] = spec[1] ? v[g-1] : (spec[0] ? aux[g] : inr[g]);
    end
    for (g = 0; g < NV; g++) begin : g_alu
      assign res[g] = alu(root, prefix, v[g], opnd[g], aux[g]);
      assign var_q[g*DW +: DW] = v[g];
      assign aux_q[g*DW +: DW] = aux[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NV; i++) begin
        v[i] <= '0; inr[i] <= '0; aux[i] <= '0;
      end
      key <= '0; akey <= '0; bad_fmt <= 1'b0;
    end else begin
      bad_fmt <= run && !known;
      if (page_ld) begin
        for (int i = 0; i < NV; i++) begin
          v[i]   <= page_var[i*DW +: DW];
          inr[i] <= page_in[i*DW +: DW];
        end
        key <= page_key;
      end else if (run && known) begin
        for (int i = 0; i < NV; i++)
          if (suffix[i]) begin
            v[i] <= res[i];
            if (root == OP_SWP) aux[i] <= v[i];
          end
        if (root == OP_SWP && prefix[1]) begin
          key <= akey; akey <= key;
        end
      end
    end
  end

  assign key_q  = key;
  assign akey_q = akey;

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    page_ld |=> var_q == $past(page_var) && key_q == $past(page_key));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step && !page_ld && cw[3:0] == 4'd0 |=> $stable(var_q));
  p_swap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    step && !page_ld && cw[9:7] == OP_SWP && cw[0] |=> aux_q[DW-1:0] == $past(var_q[DW-1:0]));
  p_spare_r12: assert property (@(posedge clk) disable iff (!rst_n)
    step && !page_ld && cw[9:8] == 2'b11 |=> bad_fmt && $stable(var_q) && $stable(aux_q) && $stable(key_q));
  p_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bad_fmt |-> $past(step) && !$past(page_ld));
endmodule

// File: tb/varnet_slot_bench.sv
module varnet_slot_bench;
  logic        clk = 0, rst_n = 0, page_ld = 0, step = 0;
  logic [63:0] page_var = '0, page_in = '0;
  logic [7:0]  page_key = '0;
  logic [11:0] cw = '0;
  logic [63:0] var_q, aux_q;
  logic [7:0]  key_q, akey_q;
  logic        bad_fmt;
  int nvec = 0, nbad = 0;

  varnet_slot u_varnet_slot (.clk, .rst_n, .page_ld, .page_var, .page_in, .page_key,
    .step, .cw, .var_q, .aux_q, .key_q, .akey_q, .bad_fmt);

  always #2 clk = ~clk;

  // {cw, expected {D,C,B,A}} applied in order from page A..D=16,32,48,64; a..d=5..8
  localparam logic [75:0] VEC [10] = '{
    {12'h04F, 64'h0008_0007_0006_0005},  // R7 R5 R4 load from inputs
    {12'h06F, 64'h0007_0006_0005_0007},  // R6 chain shift, A<-c
    {12'h08F, 64'h000F_000D_000B_000E},  // R7 wrapping add
    {12'h12A, 64'h0002_000D_FFFD_000E},  // R9 R3 subtract neighbour, B,D only
    {12'h1A6, 64'h0002_0010_0011_000E},  // R9 absolute difference
    {12'h613, 64'h0002_0010_0000_0004},  // R10 shift by 2, B from aux
    {12'h285, 64'h0002_0000_0000_0000},  // R11 swap A,C with aux
    {12'h01C, 64'h0000_0010_0000_0000},  // R5 load C,D from aux
    {12'h0D1, 64'h0000_0010_0000_0006},  // R4 A += b
    {12'h222, 64'h0000_0010_0003_0006}   // R10 B <- A>>>1
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [63:0] pv, input logic [63:0] pi, input logic [7:0] k);
    @(negedge clk); page_ld = 1; page_var = pv; page_in = pi; page_key = k;
    @(negedge clk); page_ld = 0;
  endtask

  task automatic run(input logic [11:0] w);
    @(negedge clk); step = 1; cw = w;
    @(negedge clk); step = 0;
  endtask

  initial begin
    #100000;
    nbad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 var", var_q, '0);
    chk("R1 aux", aux_q, '0);
    chk("R1 keys", {48'h0, key_q, akey_q}, '0);
    chk("R1 flag", {63'h0, bad_fmt}, '0);
    rst_n = 1;

    load(64'h0040_0030_0020_0010, 64'h0008_0007_0006_0005, 8'h3C);
    chk("R2 load", var_q, 64'h0040_0030_0020_0010);
    for (int i = 0; i < 10; i++) begin
      run(VEC[i][75:64]);
      chk($sformatf("vector %0d", i), var_q, VEC[i][63:0]);
    end
    chk("R11 aux after swap", aux_q, 64'h0000_0010_0000_0004);

    run(12'h04F & 12'hFF0);
    chk("R3 empty suffix", var_q, 64'h0000_0010_0003_0006);

    run(12'hA80);
    chk("R11 key swap", {48'h0, key_q, akey_q}, {48'h0, 8'h00, 8'h3C});
    chk("R3 key swap leaves vars", var_q, 64'h0000_0010_0003_0006);

    run(12'h30F);
    chk("R12 flag", {63'h0, bad_fmt}, 64'h1);
    chk("R12 vars hold", var_q, 64'h0000_0010_0003_0006);
    chk("R12 aux hold", aux_q, 64'h0000_0010_0000_0004);
    @(negedge clk);
    chk("R12 flag clears", {63'h0, bad_fmt}, '0);
    run(12'hB8F);
    chk("R12 root 7 flag", {63'h0, bad_fmt}, 64'h1);

    load(64'h0000_0000_0000_7FF0, 64'h0000_0000_0000_0020, 8'h11);
    run(12'h0C1);
    chk("R7 add wraps", var_q, 64'h0000_0000_0000_8010);
    load(64'h0000_0000_0000_7FF0, 64'h0000_0000_0000_0020, 8'h11);
    run(12'h4C1);
    chk("R8 positive saturate", var_q, 64'h0000_0000_0000_7FFF);
    load(64'h0000_0000_0000_8010, 64'h0000_0000_0000_FFE0, 8'h11);
    run(12'h4C1);
    chk("R8 negative saturate", var_q, 64'h0000_0000_0000_8000);

    @(negedge clk); page_ld = 1; step = 1; cw = 12'h04F;
    page_var = 64'h1111_2222_3333_4444; page_in = 64'h0009_0009_0009_0009; page_key = 8'h5A;
    @(negedge clk); page_ld = 0; step = 0;
    chk("R2 load beats step", var_q, 64'h1111_2222_3333_4444);
    chk("R2 key", {56'h0, key_q}, 64'h5A);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule